// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

After reset this block keeps an SDRAM device idle, with clock enable low and no commands on the bus. Software sets a start bit in a small control register, and the block then issues the power-up command string: a precharge of all banks, a load of the mode register, and two auto-refresh commands. The value loaded into the mode register comes from the start-address register of channel 0. During the load command that value is driven onto the SDRAM address pins. Once the load has been issued, software may put a normal address back into that channel register.

A hardware counter enforces the power-on settling time after every reset. A start request that arrives during this time is held, and the sequence runs as soon as the time has passed. The sequence runs once per reset and ends with a sticky done flag. The same control register also carries bit-level lines for the serial EEPROM on the memory module: write protect, clock, data direction and data. Software drives these lines to bit-bang the serial bus.

Top module: `sdram_pwrup_seq`

## Requirements
- R1: While reset is high, and in the first cycle after reset, sd_cke is 0, the command pins {sd_cs_n,sd_ras_n,sd_cas_n,sd_we_n} are 4'b1111, init_done is 0 and the control register reads back 0.
- R2: If control bit 0 has not been written to 1, no command is issued (sd_cs_n stays 1) and sd_cke stays 0, even after the power-up wait has expired.
- R3: Command encodings on {cs_n,ras_n,cas_n,we_n} are 0010 for precharge, 0000 for mode load, 0001 for refresh and 0111 for NOP. The sequence is precharge at cycle p, mode load at p+T_RP, refresh at p+T_RP+T_MRD, and a second refresh T_RC cycles after the first. NOP is driven in every other cycle from p onward, and sd_cke is 1 from p onward.
- R4: The address bus carries the low ADDR_W bits of the channel 0 start register during the mode load, so a value of 0x27 appears as 0x027. During the precharge, address bit 10 is 1 and the other address bits are 0.
- R5: The channel 1 to NUM_CH-1 registers have no effect on the sequence. Rewriting channel 0 after the mode load issues no command. Every channel register reads back the value last written to it.
- R6: Count the first clock edge with reset low as edge 1. No command is issued before edge PWRUP_CYCLES+1. A start bit written earlier is held, and the precharge is issued at edge PWRUP_CYCLES+1 exactly.
- R7: init_done rises T_RC cycles after the second refresh, which with the default timings is 19 cycles after the precharge and well under 2 µs at 100 MHz. It stays 1 until reset. Clearing bit 0 and setting it again does not rerun the sequence. After a reset, the block returns to idle and runs again only when bit 0 is set.
- R8: Control bits 1 to 3 read back as 0 whatever value was written to them.
- R9: Control bit 4 drives ee_wp, bit 5 drives ee_scl, bit 6 drives ee_sda_oe and bit 7 drives ee_sda_o. When bit 6 is 1, bit 7 reads back the written value. When bit 6 is 0, bit 7 reads back ee_sda_i as registered one cycle earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | SEL_W | Register select: 0 = control, k = channel k-1 start |
| reg_wdata | input | REG_W | Write data |
| reg_rdata | output | REG_W | Read data for the selected register |
| sd_cke | output | 1 | SDRAM clock enable |
| sd_cs_n | output | 1 | SDRAM chip select, active low |
| sd_ras_n | output | 1 | SDRAM row strobe, active low |
| sd_cas_n | output | 1 | SDRAM column strobe, active low |
| sd_we_n | output | 1 | SDRAM write enable, active low |
| sd_addr | output | ADDR_W | SDRAM address bus |
| init_done | output | 1 | Sequence complete (sticky) |
| ee_wp | output | 1 | EEPROM write protect |
| ee_scl | output | 1 | EEPROM serial clock |
| ee_sda_o | output | 1 | EEPROM data out |
| ee_sda_oe | output | 1 | EEPROM data drive enable |
| ee_sda_i | input | 1 | EEPROM data pin sampled |

## Verification
The bench writes the start bit thousands of cycles before the power-up wait ends. It then expects the precharge on the exact edge at which the wait expires: a design that drops the early request would never start, and one that ignores the counter would start at once. It checks the spacing of every command against the timing parameters, and checks the address bus on the mode load against a channel 0 value that differs between runs, while other channels are written during the sequence. A design that took the mode value from the wrong register, swapped the order of the commands or miscounted a wait would produce a mismatch in the scoreboard. After completion the bench toggles the start bit and rewrites channel 0 to catch a design that reruns the sequence, and it probes the masked bits and both directions of the serial data line.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

    // {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_MRS   = 4'b0000,
        CMD_REF   = 4'b0001,
        CMD_PRE   = 4'b0010,
        CMD_NOP   = 4'b0111,
        CMD_DESEL = 4'b1111
    } sd_cmd_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PRE,
        ST_W_RP,
        ST_MRS,
        ST_W_MRD,
        ST_REF1,
        ST_W_RC1,
        ST_REF2,
        ST_W_RC2,
        ST_DONE
    } seq_state_e;

    typedef struct packed {
        logic sda_data;
        logic sda_dir;
        logic scl;
        logic wp;
        logic start;
    } ctrl_t;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } cmd_pins_t;

    localparam int AP_BIT = 10;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    function automatic ctrl_t ctrl_from_byte(input logic [7:0] b);
        ctrl_t c;
        c.sda_data = b[7];
        c.sda_dir  = b[6];
        c.scl      = b[5];
        c.wp       = b[4];
        c.start    = b[0];
        return c;
    endfunction

    function automatic logic [7:0] ctrl_to_byte(input ctrl_t c, input logic sda_pin);
        logic bit7;
        bit7 = c.sda_dir ? c.sda_data : sda_pin;
        return {bit7, c.sda_dir, c.scl, c.wp, 3'b000, c.start};
    endfunction

endpackage

// File: rtl/sdram_init_regs.sv
module sdram_init_regs
    import sdram_init_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int REG_W  = 24,
    parameter int ADDR_W = 13,
    parameter int SEL_W  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [SEL_W-1:0]  reg_sel,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              sda_pin,
    output ctrl_t             ctrl,
    output logic              start_req,
    output logic [ADDR_W-1:0] mode_val
);

    logic [REG_W-1:0] ch_q [NUM_CH];
    logic             sda_smp;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl      <= '0;
            start_req <= 1'b0;
            sda_smp   <= 1'b0;
        end else begin
            sda_smp <= sda_pin;
            if (reg_wr && reg_sel == '0) begin
                ctrl <= ctrl_from_byte(reg_wdata[7:0]);
                if (reg_wdata[0]) begin
                    start_req <= 1'b1;
                end
            end
        end
    end

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        always_ff @(posedge clk) begin
            if (rst) begin
                ch_q[i] <= '0;
            end else if (reg_wr && reg_sel == SEL_W'(i + 1)) begin
                ch_q[i] <= reg_wdata;
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_sel == '0) begin
            reg_rdata = REG_W'(ctrl_to_byte(ctrl, sda_smp));
        end else begin
            for (int i = 0; i < NUM_CH; i++) begin
                if (reg_sel == SEL_W'(i + 1)) begin
                    reg_rdata = ch_q[i];
                end
            end
        end
    end

    assign mode_val = ch_q[0][ADDR_W-1:0];

endmodule

// File: rtl/sdram_init_pwrup_timer.sv
module sdram_init_pwrup_timer #(
    parameter int PWRUP_CYCLES = 10000
) (
    input  logic clk,
    input  logic rst,
    output logic pwr_ok
);

    localparam int CW = $clog2(PWRUP_CYCLES + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (cnt != CW'(PWRUP_CYCLES)) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign pwr_ok = (cnt == CW'(PWRUP_CYCLES));

endmodule

// File: rtl/sdram_init_fsm.sv
module sdram_init_fsm
    import sdram_init_pkg::*;
#(
    parameter int T_RP  = 3,
    parameter int T_MRD = 2,
    parameter int T_RC  = 7
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start_req,
    input  logic       pwr_ok,
    output sd_cmd_e    cmd,
    output logic       cke,
    output logic       done,
    output seq_state_e state
);

    localparam int TMAX = max3(T_RP, T_MRD, T_RC);
    localparam int CNT_W = $clog2(TMAX + 1);

    logic [CNT_W-1:0] wcnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            wcnt  <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (start_req && pwr_ok) state <= ST_PRE;
                ST_PRE: begin
                    wcnt  <= CNT_W'(T_RP - 2);
                    state <= ST_W_RP;
                end
                ST_W_RP: begin
                    if (wcnt == '0) state <= ST_MRS;
                    else            wcnt  <= wcnt - 1'b1;
                end
                ST_MRS: begin
                    wcnt  <= CNT_W'(T_MRD - 2);
                    state <= ST_W_MRD;
                end
                ST_W_MRD: begin
                    if (wcnt == '0) state <= ST_REF1;
                    else            wcnt  <= wcnt - 1'b1;
                end
                ST_REF1: begin
                    wcnt  <= CNT_W'(T_RC - 2);
                    state <= ST_W_RC1;
                end
                ST_W_RC1: begin
                    if (wcnt == '0) state <= ST_REF2;
                    else            wcnt  <= wcnt - 1'b1;
                end
                ST_REF2: begin
                    wcnt  <= CNT_W'(T_RC - 2);
                    state <= ST_W_RC2;
                end
                ST_W_RC2: begin
                    if (wcnt == '0) state <= ST_DONE;
                    else            wcnt  <= wcnt - 1'b1;
                end
                ST_DONE: state <= ST_DONE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        unique case (state)
            ST_IDLE: cmd = CMD_DESEL;
            ST_PRE:  cmd = CMD_PRE;
            ST_MRS:  cmd = CMD_MRS;
            ST_REF1: cmd = CMD_REF;
            ST_REF2: cmd = CMD_REF;
            default: cmd = CMD_NOP;
        endcase
    end

    assign cke  = (state != ST_IDLE);
    assign done = (state == ST_DONE);

endmodule

// File: rtl/sdram_pwrup_seq.sv
module sdram_pwrup_seq
    import sdram_init_pkg::*;
#(
    parameter int NUM_CH       = 4,
    parameter int REG_W        = 24,
    parameter int ADDR_W       = 13,
    parameter int PWRUP_CYCLES = 10000,
    parameter int T_RP         = 3,
    parameter int T_MRD        = 2,
    parameter int T_RC         = 7,
    localparam int SEL_W       = $clog2(NUM_CH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [SEL_W-1:0]  reg_sel,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              sd_cke,
    output logic              sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic [ADDR_W-1:0] sd_addr,
    output logic              init_done,
    output logic              ee_wp,
    output logic              ee_scl,
    output logic              ee_sda_o,
    output logic              ee_sda_oe,
    input  logic              ee_sda_i
);

    ctrl_t             ctrl;
    logic              start_req;
    logic              pwr_ok;
    logic [ADDR_W-1:0] ch0_mode;
    sd_cmd_e           cmd;
    seq_state_e        state;
    cmd_pins_t         pins;

    sdram_init_regs #(
        .NUM_CH(NUM_CH), .REG_W(REG_W), .ADDR_W(ADDR_W), .SEL_W(SEL_W)
    ) u_regs (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sda_pin(ee_sda_i),
        .ctrl(ctrl), .start_req(start_req), .mode_val(ch0_mode)
    );

    sdram_init_pwrup_timer #(.PWRUP_CYCLES(PWRUP_CYCLES)) u_timer (
        .clk(clk), .rst(rst), .pwr_ok(pwr_ok)
    );

    sdram_init_fsm #(.T_RP(T_RP), .T_MRD(T_MRD), .T_RC(T_RC)) u_fsm (
        .clk(clk), .rst(rst), .start_req(start_req), .pwr_ok(pwr_ok),
        .cmd(cmd), .cke(sd_cke), .done(init_done), .state(state)
    );

    assign pins     = cmd_pins_t'(cmd);
    assign sd_cs_n  = pins.cs_n;
    assign sd_ras_n = pins.ras_n;
    assign sd_cas_n = pins.cas_n;
    assign sd_we_n  = pins.we_n;

    always_comb begin
        sd_addr = '0;
        if (state == ST_MRS) begin
            sd_addr = ch0_mode;
        end else if (state == ST_PRE) begin
            sd_addr[AP_BIT] = 1'b1;
        end
    end

    assign ee_wp     = ctrl.wp;
    assign ee_scl    = ctrl.scl;
    assign ee_sda_oe = ctrl.sda_dir;
    assign ee_sda_o  = ctrl.sda_data;

endmodule

// File: rtl/sdram_init_checker.sv
module sdram_init_checker #(
    parameter int ADDR_W       = 13,
    parameter int PWRUP_CYCLES = 10000
) (
    input logic              clk,
    input logic              rst,
    input logic              sd_cke,
    input logic              sd_cs_n,
    input logic              sd_ras_n,
    input logic              sd_cas_n,
    input logic              sd_we_n,
    input logic [ADDR_W-1:0] sd_addr,
    input logic              init_done,
    input logic [ADDR_W-1:0] mode_val
);

    localparam int CW = $clog2(PWRUP_CYCLES + 1);

    logic [CW-1:0] since_rst;
    logic          seen_pre, seen_mrs;
    logic [1:0]    ref_seen;
    logic          is_pre, is_mrs, is_ref;

    assign is_pre = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0010;
    assign is_mrs = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0000;
    assign is_ref = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0001;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_rst <= '0;
            seen_pre  <= 1'b0;
            seen_mrs  <= 1'b0;
            ref_seen  <= '0;
        end else begin
            if (since_rst != CW'(PWRUP_CYCLES)) since_rst <= since_rst + 1'b1;
            if (is_pre) seen_pre <= 1'b1;
            if (is_mrs) seen_mrs <= 1'b1;
            if (is_ref && ref_seen != 2'd3) ref_seen <= ref_seen + 1'b1;
        end
    end

    a_r6_no_cmd_in_wait: assert property (@(posedge clk) disable iff (rst)
        (since_rst < CW'(PWRUP_CYCLES)) |-> sd_cs_n);

    a_r3_cke_with_cmd: assert property (@(posedge clk) disable iff (rst)
        !sd_cs_n |-> sd_cke);

    a_r3_pre_first: assert property (@(posedge clk) disable iff (rst)
        is_pre |-> !seen_pre);

    a_r3_mrs_after_pre: assert property (@(posedge clk) disable iff (rst)
        is_mrs |-> (seen_pre && !seen_mrs));

    a_r3_ref_after_mrs: assert property (@(posedge clk) disable iff (rst)
        is_ref |-> (seen_mrs && ref_seen < 2'd2));

    a_r4_mode_on_bus: assert property (@(posedge clk) disable iff (rst)
        is_mrs |-> (sd_addr == mode_val));

    a_r4_pre_all_banks: assert property (@(posedge clk) disable iff (rst)
        is_pre |-> sd_addr[10]);

    a_r7_done_after_refs: assert property (@(posedge clk) disable iff (rst)
        $rose(init_done) |-> (ref_seen == 2'd2));

    a_r7_done_sticky: assert property (@(posedge clk) disable iff (rst)
        init_done |=> init_done);

endmodule

bind sdram_pwrup_seq sdram_init_checker #(
    .ADDR_W(ADDR_W), .PWRUP_CYCLES(PWRUP_CYCLES)
) u_chk (
    .clk(clk), .rst(rst), .sd_cke(sd_cke), .sd_cs_n(sd_cs_n),
    .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
    .sd_addr(sd_addr), .init_done(init_done), .mode_val(ch0_mode)
);

// File: tb/sdram_pwrup_seq_bench.sv
module sdram_pwrup_seq_bench;

    localparam int NCYC = 10000;
    localparam int TRP = 3, TMRD = 2, TRC = 7;
    localparam int TOTAL = TRP + TMRD + 2 * TRC;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_sel = '0;
    logic [23:0] reg_wdata = '0;
    logic [23:0] reg_rdata;
    logic        sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
    logic [12:0] sd_addr;
    logic        init_done;
    logic        ee_wp, ee_scl, ee_sda_o, ee_sda_oe;
    logic        ee_sda_i = 1'b0;

    int total = 0;
    int bad = 0;
    int cyc;

    typedef struct {
        int          at;
        logic [3:0]  cmd;
        logic [12:0] addr;
        string       req;
    } exp_t;
    exp_t sb[$];

    always #5 clk = ~clk;

    sdram_pwrup_seq u_sdram_pwrup_seq (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sd_cke(sd_cke),
        .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n),
        .sd_we_n(sd_we_n), .sd_addr(sd_addr), .init_done(init_done),
        .ee_wp(ee_wp), .ee_scl(ee_scl), .ee_sda_o(ee_sda_o),
        .ee_sda_oe(ee_sda_oe), .ee_sda_i(ee_sda_i)
    );

    always @(posedge clk) begin
        if (rst) cyc <= 0;
        else     cyc <= cyc + 1;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor: every non-NOP command is matched against the scoreboard
    always @(negedge clk) begin
        if (!rst) begin
            logic [3:0] c;
            c = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
            if (!sd_cs_n && c != 4'b0111) begin
                if (sb.size() == 0) begin
                    check("R2/R5/R7 unexpected command", c, 4'b1111);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check({e.req, " cycle"}, cyc, e.at);
                    check({e.req, " cmd"}, c, e.cmd);
                    check({e.req, " addr"}, sd_addr, e.addr);
                end
            end
        end
    end

    task automatic push_seq(input int p, input logic [12:0] mode);
        sb.push_back('{p, 4'b0010, 13'h0400, "R3/R4 precharge"});
        sb.push_back('{p + TRP, 4'b0000, mode, "R3/R4 mode load"});
        sb.push_back('{p + TRP + TMRD, 4'b0001, 13'h0, "R3 refresh1"});
        sb.push_back('{p + TRP + TMRD + TRC, 4'b0001, 13'h0, "R3 refresh2"});
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wr(input logic [2:0] sel, input logic [23:0] d, output int w);
        w = cyc;
        reg_sel = sel;
        reg_wdata = d;
        reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] sel, output logic [23:0] d);
        reg_sel = sel;
        #1;
        d = reg_rdata;
    endtask

    task automatic wait_until(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    initial begin
        fork
            begin
                #1500000;
                bad++;
                total++;
                $display("FAIL watchdog expired");
                $display("test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        join_none
    end

    initial begin
        int w, p;
        logic [23:0] d;

        // ---- Phase A: early start, held until the wait expires ----
        repeat (2) @(negedge clk);
        check("R1 cke in reset", sd_cke, 1'b0);
        check("R1 pins in reset", {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, 4'b1111);
        rst = 1'b0;
        @(negedge clk);
        check("R1 cke idle", sd_cke, 1'b0);
        check("R1 pins idle", {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, 4'b1111);
        check("R1 done low", init_done, 1'b0);
        rd(3'd0, d);
        check("R1 ctrl readback", d, 24'h0);

        p = NCYC + 1;
        push_seq(p, 13'h027);
        wr(3'd1, 24'h000027, w);
        wr(3'd3, 24'h001FFF, w);
        wr(3'd0, 24'h000001, w);
        wait_until(NCYC - 1);
        check("R6 still idle before wait", sd_cke, 1'b0);
        wait_until(p + TOTAL - 1);
        check("R7 done not early", init_done, 1'b0);
        check("R3 cke during run", sd_cke, 1'b1);
        @(negedge clk);
        check("R7 done rises", init_done, 1'b1);
        check("R3 all commands issued", sb.size(), 0);

        // ---- after completion: no rerun ----
        wr(3'd1, 24'h123456, w);
        wr(3'd0, 24'h000000, w);
        wr(3'd0, 24'h000001, w);
        repeat (40) @(negedge clk);
        check("R7 done sticky", init_done, 1'b1);
        rd(3'd1, d);
        check("R5 ch0 reload readback", d, 24'h123456);
        rd(3'd3, d);
        check("R5 ch2 readback", d, 24'h001FFF);

        // ---- control register / EEPROM lines ----
        wr(3'd0, 24'h0000FE, w);
        rd(3'd0, d);
        check("R8 masked bits, R9 bit7 driven", d, 24'h0000F0);
        check("R9 wp", ee_wp, 1'b1);
        check("R9 scl", ee_scl, 1'b1);
        check("R9 sda_oe", ee_sda_oe, 1'b1);
        check("R9 sda_o", ee_sda_o, 1'b1);
        wr(3'd0, 24'h00003E, w);
        check("R9 sda_oe off", ee_sda_oe, 1'b0);
        check("R9 sda_o low", ee_sda_o, 1'b0);
        ee_sda_i = 1'b1;
        repeat (2) @(negedge clk);
        rd(3'd0, d);
        check("R9 sense pin high", d, 24'h0000B0);
        ee_sda_i = 1'b0;
        repeat (2) @(negedge clk);
        rd(3'd0, d);
        check("R9 sense pin low", d, 24'h000030);
        check("R7 no rerun", sb.size(), 0);

        // ---- Phase B: reset, no start, then late start ----
        do_reset();
        @(negedge clk);
        check("R7 done cleared by reset", init_done, 1'b0);
        check("R1 cke after reset", sd_cke, 1'b0);
        wr(3'd1, 24'h000031, w);
        wait_until(NCYC + 30);
        check("R2 no start bit: cke low", sd_cke, 1'b0);
        check("R2 no start bit: done low", init_done, 1'b0);
        check("R2 no start bit: deselect", sd_cs_n, 1'b1);
        p = cyc + 2;
        push_seq(p, 13'h031);
        wr(3'd0, 24'h000001, w);
        wr(3'd2, 24'h0005A5, w);
        wr(3'd4, 24'h000ABC, w);
        wait_until(p + TOTAL);
        check("R7 done after late start", init_done, 1'b1);
        check("R5 all commands issued", sb.size(), 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule